// File: doc/BRIEF.md
# Interrupt Pin Capture and Dispatch

This block sits between a set of interrupt input lines and a processor-side interrupt fabric. Each input pin has a 64-bit routing entry, supplied on a flat input bus. The entry sets the pin's trigger style, its mask and the fields of the message it produces. The block keeps one pending flag per pin and finds the lowest-numbered pin that is pending and unmasked. It then presents one delivery message for that pin on a valid/ready output.

When an entry selects the external-interrupt delivery style, the message does not take its vector from the entry. The block first asks a legacy interrupt controller for the vector over a request/acknowledge handshake. It then presents the message with the vector it received. The legacy input line 0 is routed to pin 2. Pin 0 receives no line at all.

Top module: `irq_route_dispatch`

## Requirements
- R1: After reset, msg_valid and leg_req are low, every pending flag is clear, and no message appears while all lines stay low.
- R2: A pin whose entry has bit 16 set is never dispatched. An edge it captured while masked stays pending and is dispatched once bit 16 is cleared.
- R3: With entry bit 15 = 0 (edge), a rising edge on the pin sets its pending flag. Exactly one message follows, and the flag clears when that message is accepted.
- R4: With entry bit 15 = 1 (level), the pending flag follows the pin level. Messages keep coming while the level is high and stop once it is low.
- R5: Message fields come from the entry of the dispatched pin: destination from bits 63:56, destination mode from bit 11, delivery mode from bits 10:8, vector from bits 7:0, polarity from bit 13 and trigger mode from bit 15.
- R6: With delivery mode 7 (external interrupt), leg_req rises and msg_valid stays low until leg_ack. The message then carries leg_vector, sampled at the acknowledge edge, in place of entry bits 7:0.
- R7: When several pins are eligible, the lowest-numbered one is dispatched first.
- R8: Line 0 and line 2 both drive pin 2. Pin 0 is driven by no line. Every other line N drives pin N.
- R9: While msg_valid is high and msg_ready is low, msg_valid and every message field hold steady. Each accepted handshake carries exactly one message.
- R10: For an idle block and a pin in edge mode, msg_valid rises at the second rising clock edge after the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 24 | Interrupt input lines |
| route_tbl | input | 1536 | 24 routing entries of 64 bits; entry N at bits N*64+63 down to N*64 |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dmode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_polarity | output | 1 | Pin polarity |
| msg_trigger | output | 1 | Trigger mode (0 edge, 1 level) |
| leg_req | output | 1 | Vector request to the legacy controller |
| leg_ack | input | 1 | Legacy controller acknowledge |
| leg_vector | input | 8 | Vector from the legacy controller, valid with leg_ack |

## Verification
A stale pending flag shows at the ports as a second message for one edge, within a few cycles of acceptance. A lost flag shows as a message that never arrives after a line rises or a pin is unmasked. A wrong scan order shows in the first message after two lines rise on the same cycle. A decode slip shows as a wrong field on the very first message. A fault in the fetch state shows as a message that appears before the acknowledge, or one that carries the entry vector in place of the legacy vector.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENT_W = 64;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND
  } disp_st_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dmode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } route_fields_t;

  localparam logic [2:0] DM_EXTINT = 3'd7;
  localparam int         BIT_MASK  = 16;
  localparam int         BIT_TRIG  = 15;

  function automatic route_fields_t decode_entry(input logic [ENT_W-1:0] e);
    route_fields_t f;
    f.dest      = e[63:56];
    f.dest_mode = e[11];
    f.dmode     = e[10:8];
    f.vector    = e[7:0];
    f.polarity  = e[13];
    f.trigger   = e[BIT_TRIG];
    return f;
  endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NUM_PINS    = 24,
  parameter int LEGACY_SRC  = 0,
  parameter int LEGACY_DST  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lines,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] pend
);

  logic [NUM_PINS-1:0] pin_in;
  logic [NUM_PINS-1:0] prev;
  logic [NUM_PINS-1:0] rise;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == LEGACY_DST) begin : g_merge
      assign pin_in[p] = lines[p] | lines[LEGACY_SRC];
    end else if (p == LEGACY_SRC) begin : g_none
      assign pin_in[p] = 1'b0;
    end else begin : g_direct
      assign pin_in[p] = lines[p];
    end

    assign rise[p] = pin_in[p] & ~prev[p];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[p] <= 1'b0;
        pend[p] <= 1'b0;
      end else begin
        prev[p] <= pin_in[p];
        if (trig_level[p])
          pend[p] <= pin_in[p];
        else if (rise[p])
          pend[p] <= 1'b1;
        else if (clr[p])
          pend[p] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_scan.sv
module irq_scan #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] eligible,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);

  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligible[i]) idx = IDX_W'(i);
    end
  end

  assign any = |eligible;

endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       irq_lines,
  input  logic [NUM_PINS*ENT_W-1:0] route_tbl,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [7:0]                msg_dest,
  output logic                      msg_dest_mode,
  output logic [2:0]                msg_dmode,
  output logic [7:0]                msg_vector,
  output logic                      msg_polarity,
  output logic                      msg_trigger,
  output logic                      leg_req,
  input  logic                      leg_ack,
  input  logic [7:0]                leg_vector
);

  logic [NUM_PINS-1:0] masked_vec;
  logic [NUM_PINS-1:0] level_vec;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] clr_vec;
  logic                any_elig;
  logic [IDX_W-1:0]    sel_idx;
  logic [IDX_W-1:0]    cur_idx;
  logic [ENT_W-1:0]    sel_entry;
  route_fields_t       sel_fields;
  route_fields_t       cur;
  disp_st_e            state;
  logic                sel_fire;
  logic                accept;
  logic                sel_extint;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
    assign masked_vec[p] = route_tbl[p*ENT_W + BIT_MASK];
    assign level_vec[p]  = route_tbl[p*ENT_W + BIT_TRIG];
  end

  irq_capture #(.NUM_PINS(NUM_PINS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (irq_lines),
    .trig_level(level_vec),
    .clr       (clr_vec),
    .pend      (pend)
  );

  assign eligible = pend & ~masked_vec;

  irq_scan #(.NUM_PINS(NUM_PINS)) u_scan (
    .eligible(eligible),
    .any     (any_elig),
    .idx     (sel_idx)
  );

  assign sel_entry  = route_tbl[sel_idx*ENT_W +: ENT_W];
  assign sel_fields = decode_entry(sel_entry);
  assign sel_fire   = (state == ST_IDLE) && any_elig;
  assign sel_extint = sel_fields.dmode == DM_EXTINT;
  assign accept     = (state == ST_SEND) && msg_ready;

  always_comb begin
    clr_vec = '0;
    if (accept && !cur.trigger) clr_vec[cur_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur     <= '0;
      cur_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sel_fire) begin
            cur     <= sel_fields;
            cur_idx <= sel_idx;
            state   <= sel_extint ? ST_FETCH : ST_SEND;
          end
        end
        ST_FETCH: begin
          if (leg_ack) begin
            cur.vector <= leg_vector;
            state      <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (msg_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid     = state == ST_SEND;
  assign leg_req       = state == ST_FETCH;
  assign msg_dest      = cur.dest;
  assign msg_dest_mode = cur.dest_mode;
  assign msg_dmode     = cur.dmode;
  assign msg_vector    = cur.vector;
  assign msg_polarity  = cur.polarity;
  assign msg_trigger   = cur.trigger;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_dest,
  input logic                msg_dest_mode,
  input logic [2:0]          msg_dmode,
  input logic [7:0]          msg_vector,
  input logic                msg_polarity,
  input logic                msg_trigger,
  input logic                leg_req,
  input logic                leg_ack,
  input logic                sel_fire,
  input logic                sel_extint,
  input logic [IDX_W-1:0]    sel_idx,
  input logic [NUM_PINS-1:0] eligible,
  input logic [NUM_PINS-1:0] masked_vec
);

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_dest, msg_dest_mode, msg_dmode, msg_vector, msg_polarity, msg_trigger})); // R9

  AST_MASKED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |-> !masked_vec[sel_idx]); // R2

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |-> eligible[sel_idx] &&
      ((eligible & ((NUM_PINS'(1) << sel_idx) - NUM_PINS'(1))) == '0)); // R7

  AST_EXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire && sel_extint |=> leg_req && !msg_valid); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    leg_req && !leg_ack |=> leg_req); // R6

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_req && msg_valid)); // R6

endmodule

bind irq_route_dispatch irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_dest     (msg_dest),
  .msg_dest_mode(msg_dest_mode),
  .msg_dmode    (msg_dmode),
  .msg_vector   (msg_vector),
  .msg_polarity (msg_polarity),
  .msg_trigger  (msg_trigger),
  .leg_req      (leg_req),
  .leg_ack      (leg_ack),
  .sel_fire     (sel_fire),
  .sel_extint   (sel_extint),
  .sel_idx      (sel_idx),
  .eligible     (eligible),
  .masked_vec   (masked_vec)
);

// File: tb/irq_route_dispatch_bench.sv
module irq_route_dispatch_bench;

  localparam int NP = 24;
  localparam int NROW = 5;
  localparam logic [63:0] MASKED = 64'h1_0000;

  typedef struct packed {
    logic [4:0]  line;
    logic [4:0]  pin;
    logic [63:0] entry;
  } row_t;

  localparam row_t ROWS [NROW] = '{
    '{5'd1,  5'd1,  64'hA500_0000_0000_0830},
    '{5'd4,  5'd4,  64'h3C00_0000_0000_2441},
    '{5'd7,  5'd7,  64'h0100_0000_0000_0152},
    '{5'd23, 5'd23, 64'hFF00_0000_0000_2A99},
    '{5'd0,  5'd2,  64'h7700_0000_0000_0560}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0] irq_lines = '0;
  logic [63:0] tbl [NP];
  logic [NP*64-1:0] route_tbl;
  logic msg_valid, msg_ready = 0;
  logic [7:0] msg_dest, msg_vector, leg_vector = '0;
  logic msg_dest_mode, msg_polarity, msg_trigger, leg_req, leg_ack = 0;
  logic [2:0] msg_dmode;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) route_tbl[i*64 +: 64] = tbl[i];

  irq_route_dispatch u_irq_route_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .route_tbl(route_tbl),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_dmode(msg_dmode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger),
    .leg_req(leg_req), .leg_ack(leg_ack), .leg_vector(leg_vector));

  function automatic logic [21:0] expect_msg(input logic [63:0] e);
    return {8'(e >> 56), e[11], 3'((e >> 8) & 64'h7), e[7:0], e[13], e[15]};
  endfunction

  function automatic logic [21:0] seen_msg();
    return {msg_dest, msg_dest_mode, msg_dmode, msg_vector, msg_polarity, msg_trigger};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < NP; i++) tbl[i] = MASKED;
  endtask

  task automatic take(output logic [21:0] m, output bit got);
    got = 0;
    m = '0;
    for (int i = 0; i < 30 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
    if (got) begin
      m = seen_msg();
      msg_ready = 1;
      @(posedge clk);
      @(negedge clk);
      msg_ready = 0;
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    msg_ready = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    msg_ready = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [21:0] m, m2;
    bit got;
    int seen;
    clear_tbl();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk(!msg_valid && !leg_req, "R1", {msg_valid, leg_req}, 0);
    quiet(6, seen);
    chk(seen == 0, "R1 idle", seen, 0);

    // R5, R3: table walk, one message per edge, fields decoded
    for (int r = 0; r < NROW; r++) begin
      clear_tbl();
      tbl[ROWS[r].pin] = ROWS[r].entry;
      @(negedge clk);
      irq_lines[ROWS[r].line] = 1;
      take(m, got);
      irq_lines = '0;
      chk(got && m == expect_msg(ROWS[r].entry), "R5 fields", m, expect_msg(ROWS[r].entry));
      quiet(6, seen);
      chk(seen == 0, "R3 single message", seen, 0);
    end

    // R10, R9: latency and hold while not ready
    clear_tbl();
    tbl[5] = 64'h1200_0000_0000_0077;
    @(negedge clk);
    irq_lines[5] = 1;
    @(negedge clk);
    chk(!msg_valid, "R10 one edge", msg_valid, 0);
    @(negedge clk);
    chk(msg_valid, "R10 two edges", msg_valid, 1);
    m = seen_msg();
    repeat (3) @(negedge clk);
    chk(msg_valid && seen_msg() == m, "R9 hold", seen_msg(), m);
    take(m2, got);
    irq_lines = '0;
    quiet(5, seen);
    chk(seen == 0, "R9 one per handshake", seen, 0);

    // R2: masked edge kept pending, released on unmask
    clear_tbl();
    tbl[6] = MASKED | 64'h0000_0000_0000_0066;
    @(negedge clk);
    irq_lines[6] = 1;
    @(negedge clk);
    irq_lines[6] = 0;
    quiet(6, seen);
    chk(seen == 0, "R2 masked", seen, 0);
    tbl[6] = 64'h0000_0000_0000_0066;
    take(m, got);
    chk(got && m[9:2] == 8'h66, "R2 unmask", m[9:2], 8'h66);

    // R7: simultaneous edges on pins 12 and 3
    clear_tbl();
    tbl[3]  = 64'h0000_0000_0000_0033;
    tbl[12] = 64'h0000_0000_0000_00C2;
    @(negedge clk);
    irq_lines[12] = 1;
    irq_lines[3]  = 1;
    take(m, got);
    take(m2, got);
    irq_lines = '0;
    chk(m[9:2] == 8'h33, "R7 first", m[9:2], 8'h33);
    chk(m2[9:2] == 8'hC2, "R7 second", m2[9:2], 8'hC2);

    // R8: line 0 reaches pin 2 only, line 2 also reaches pin 2
    clear_tbl();
    tbl[0] = 64'h0000_0000_0000_0010;
    tbl[2] = 64'h0000_0000_0000_0020;
    @(negedge clk);
    irq_lines[0] = 1;
    take(m, got);
    chk(got && m[9:2] == 8'h20, "R8 line0->pin2", m[9:2], 8'h20);
    quiet(6, seen);
    chk(seen == 0, "R8 pin0 silent", seen, 0);
    irq_lines = '0;
    @(negedge clk);
    irq_lines[2] = 1;
    take(m, got);
    irq_lines = '0;
    chk(got && m[9:2] == 8'h20, "R8 line2", m[9:2], 8'h20);

    // R4: level pin repeats while high, stops when low
    clear_tbl();
    tbl[9] = 64'h0000_0000_0000_8045;
    @(negedge clk);
    irq_lines[9] = 1;
    quiet(12, seen);
    chk(seen >= 3, "R4 repeat", seen, 3);
    irq_lines[9] = 0;
    quiet(4, seen);
    quiet(6, seen);
    chk(seen == 0, "R4 stop", seen, 0);

    // R6: external-interrupt vector fetch
    clear_tbl();
    tbl[11] = 64'h4400_0000_0000_0711;
    @(negedge clk);
    irq_lines[11] = 1;
    repeat (2) @(negedge clk);
    chk(leg_req && !msg_valid, "R6 request", {leg_req, msg_valid}, 2'b10);
    repeat (2) @(negedge clk);
    chk(leg_req && !msg_valid, "R6 wait", {leg_req, msg_valid}, 2'b10);
    leg_vector = 8'hC7;
    leg_ack = 1;
    @(negedge clk);
    leg_ack = 0;
    leg_vector = 8'h00;
    chk(msg_valid && !leg_req, "R6 send", {msg_valid, leg_req}, 2'b10);
    chk(msg_vector == 8'hC7 && msg_dmode == 3'd7, "R6 vector", {msg_dmode, msg_vector}, {3'd7, 8'hC7});
    take(m, got);
    irq_lines = '0;
    quiet(5, seen);
    chk(seen == 0 && !leg_req, "R6 done", seen, 0);

    summary();
    $finish;
  end

endmodule